// File: doc/BRIEF.md
# Instruction Packet Framer with Duplex Splitting

This block takes a stream of 32-bit instruction words over a valid/ready input. It collects consecutive words into one packet until a word marks the end of that packet. Each word becomes one or more instruction records in an internal packet buffer. A word that packs two half-size sub-instructions is split into two records, and each of them carries a 4-bit group class. Constant-extender words do not produce a record of their own. Their payload is merged into the immediate of the next record.

When a packet closes, the block may append a synthetic loop-end record. Whether it does, and which kind, depends on which word positions carried a loop-end marker. The block raises a packet-valid level together with the record count, the packet size in bytes and an error flag. It stops taking input until the consumer acknowledges the packet. Records are read through a combinational index port. Opcode decoding is left to later stages; the records hold raw fields only.

Top module: `pkt_framer`

## Requirements
- R1: After reset `in_ready` is 1, `pkt_valid` is 0 and `pkt_count` is 0.
- R2: A word is accepted on a rising edge with `in_valid` and `in_ready` high. Parse bits are bits [15:14]. The value 11 closes the packet. On the edge that accepts the closing word, `pkt_valid` goes to 1, `pkt_bytes` becomes 4 times the words taken, and `pkt_count` becomes the number of records. A word that is neither a duplex nor an extender gives one record of kind 0 whose raw field is the whole word.
- R3: A word with parse bits 00 is a duplex. It gives two records in this order: kind 1 with raw = word[28:16], then kind 2 with raw = word[12:0]. Both carry group = {word[31:29], word[13]}.
- R4: A duplex whose group equals 4'hF sets `pkt_err`. The packet is still framed normally.
- R5: Parse bits 10 mark a loop end. For a 2-word packet with the marker on word 0, a kind-3 record with raw 1 is appended as the last record.
- R6: For packets of 3 or more words, the appended kind-3 record has raw 3 when words 0 and 1 both carry markers, raw 2 when only word 1 does, and raw 1 when only word 0 does.
- R7: No loop-end record is added for a 1-word packet or when markers appear only on words from index 2 onward.
- R8: A non-duplex word with bits [31:28] = 0 is an extender and adds no record. Its value is {word[27:16], word[13:0], 6'b0}. The next record gets ext = 1 and imm = value OR its raw[5:0]. Every other record has ext = 0 and imm = raw[5:0].
- R9: An extender that is itself the closing word sets `pkt_err`.
- R10: If the 4th word (MAX_WORDS) does not close the packet, the packet ends on that word with `pkt_err` = 1 and `pkt_bytes` = 16.
- R11: While `pkt_valid` is 1, `in_ready` is 0 and the count holds. An edge with `pkt_ack` returns the block to idle, ready for the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Instruction word |
| in_ready | output | 1 | Block can take a word |
| pkt_valid | output | 1 | Framed packet available |
| pkt_err | output | 1 | Packet is illegal |
| pkt_count | output | 4 | Number of records in the packet |
| pkt_bytes | output | 5 | Packet size in bytes |
| pkt_ack | input | 1 | Consumer has taken the packet |
| rd_idx | input | 4 | Record index to read |
| rd_kind | output | 2 | Record kind: 0 normal, 1 upper sub, 2 lower sub, 3 loop end |
| rd_raw | output | 32 | Raw word, sub-instruction or loop code |
| rd_grp | output | 4 | Duplex group class |
| rd_ext | output | 1 | Record was extended |
| rd_imm | output | 32 | Immediate after extension |

## Verification
All packet results are registered on the same edge that accepts the closing word. So `pkt_valid`, `pkt_count`, `pkt_bytes`, `pkt_err` and the buffer contents are due one edge after that word is driven. The bench drives words on falling edges and checks these results at the falling edge that follows the closing edge. Record fields come from a combinational read port, so the bench reads them after setting `rd_idx` within that same low phase. An acknowledge takes one edge to clear the packet, and a held word is taken on the next edge; the stall test checks this timing explicitly.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        REC_NORM = 2'd0,
        REC_SUB1 = 2'd1,
        REC_SUB0 = 2'd2,
        REC_LOOP = 2'd3
    } rec_kind_e;

    typedef struct packed {
        rec_kind_e   kind;
        logic [31:0] raw;
        logic [3:0]  grp;
        logic        ext;
        logic [31:0] imm;
    } rec_t;

endpackage

// File: rtl/pf_word_split.sv
module pf_word_split (
    input  logic [31:0] word,
    output logic        is_dup,
    output logic        is_eop,
    output logic        is_lmark,
    output logic        is_ext,
    output logic [31:0] ext_val,
    output logic [3:0]  grp,
    output logic        grp_rsvd,
    output logic [12:0] sub_hi,
    output logic [12:0] sub_lo
);
    logic [1:0] parse;

    always_comb begin
        parse    = word[15:14];
        is_dup   = (parse == 2'b00);
        is_eop   = (parse == 2'b11);
        is_lmark = (parse == 2'b10);
        is_ext   = !is_dup && (word[31:28] == 4'h0);
        ext_val  = {word[27:16], word[13:0], 6'b0};
        grp      = {word[31:29], word[13]};
        grp_rsvd = is_dup && (grp == 4'hF);
        sub_hi   = word[28:16];
        sub_lo   = word[12:0];
    end
endmodule

// File: rtl/pf_loop_end.sv
module pf_loop_end #(
    parameter int WCW = 3
) (
    input  logic [WCW-1:0] n_words,
    input  logic           mark0,
    input  logic           mark1,
    output logic           el_valid,
    output logic [1:0]     el_code
);
    always_comb begin
        el_valid = 1'b0;
        el_code  = 2'd0;
        if (n_words == WCW'(2)) begin
            if (mark0) begin
                el_valid = 1'b1;
                el_code  = 2'd1;
            end
        end else if (n_words >= WCW'(3)) begin
            if (mark0 && mark1) begin
                el_valid = 1'b1;
                el_code  = 2'd3;
            end else if (mark1) begin
                el_valid = 1'b1;
                el_code  = 2'd2;
            end else if (mark0) begin
                el_valid = 1'b1;
                el_code  = 2'd1;
            end
        end
    end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
    parameter int MAX_WORDS = 4,
    localparam int DEPTH = 2 * MAX_WORDS + 1,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1),
    localparam int WCW   = $clog2(MAX_WORDS + 1),
    localparam int BW    = WCW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_word,
    output logic            in_ready,
    output logic            pkt_valid,
    output logic            pkt_err,
    output logic [CNTW-1:0] pkt_count,
    output logic [BW-1:0]   pkt_bytes,
    input  logic            pkt_ack,
    input  logic [IDXW-1:0] rd_idx,
    output logic [1:0]      rd_kind,
    output logic [31:0]     rd_raw,
    output logic [3:0]      rd_grp,
    output logic            rd_ext,
    output logic [31:0]     rd_imm
);
    import pf_pkg::*;

    localparam logic [WCW-1:0] LAST_W = WCW'(MAX_WORDS);

    typedef struct packed {
        logic                  done;
        logic                  err;
        logic [WCW-1:0]        words;
        logic [CNTW-1:0]       cnt;
        logic                  ext_pend;
        logic [31:0]           ext_val;
        logic                  mark0;
        logic                  mark1;
        rec_t [DEPTH-1:0]      recs;
    } state_t;

    state_t s_d, s_q;

    logic        sp_dup, sp_eop, sp_lmark, sp_ext, sp_rsvd;
    logic [31:0] sp_ext_val;
    logic [3:0]  sp_grp;
    logic [12:0] sp_hi, sp_lo;

    pf_word_split u_split (
        .word     (in_word),
        .is_dup   (sp_dup),
        .is_eop   (sp_eop),
        .is_lmark (sp_lmark),
        .is_ext   (sp_ext),
        .ext_val  (sp_ext_val),
        .grp      (sp_grp),
        .grp_rsvd (sp_rsvd),
        .sub_hi   (sp_hi),
        .sub_lo   (sp_lo)
    );

    logic [WCW-1:0] words_nx;
    logic           m0_eff, m1_eff;
    logic           el_valid;
    logic [1:0]     el_code;

    assign words_nx = s_q.words + 1'b1;
    assign m0_eff   = (s_q.words == '0)      ? sp_lmark : s_q.mark0;
    assign m1_eff   = (s_q.words == WCW'(1)) ? sp_lmark : s_q.mark1;

    pf_loop_end #(.WCW(WCW)) u_loop (
        .n_words  (words_nx),
        .mark0    (m0_eff),
        .mark1    (m1_eff),
        .el_valid (el_valid),
        .el_code  (el_code)
    );

    rec_t       r_a, r_b, r_c;
    logic [1:0] nrec;
    logic       use_loop;

    always_comb begin
        s_d      = s_q;
        r_a      = '0;
        r_b      = '0;
        r_c      = '0;
        nrec     = 2'd0;
        use_loop = 1'b0;
        if (s_q.done) begin
            if (pkt_ack) begin
                s_d = '0;
            end
        end else if (in_valid) begin
            s_d.words = words_nx;
            s_d.mark0 = m0_eff;
            s_d.mark1 = m1_eff;
            if (sp_ext) begin
                s_d.ext_pend = 1'b1;
                s_d.ext_val  = sp_ext_val;
            end else begin
                if (sp_dup) begin
                    r_a.kind = REC_SUB1;
                    r_a.raw  = {19'b0, sp_hi};
                    r_a.grp  = sp_grp;
                    r_a.imm  = {26'b0, sp_hi[5:0]};
                    r_b.kind = REC_SUB0;
                    r_b.raw  = {19'b0, sp_lo};
                    r_b.grp  = sp_grp;
                    r_b.imm  = {26'b0, sp_lo[5:0]};
                    nrec     = 2'd2;
                    if (sp_rsvd) begin
                        s_d.err = 1'b1;
                    end
                end else begin
                    r_a.kind = REC_NORM;
                    r_a.raw  = in_word;
                    r_a.imm  = {26'b0, in_word[5:0]};
                    nrec     = 2'd1;
                end
                if (s_q.ext_pend) begin
                    r_a.ext      = 1'b1;
                    r_a.imm      = s_q.ext_val | r_a.imm;
                    s_d.ext_pend = 1'b0;
                end
            end
            r_c.kind = REC_LOOP;
            r_c.raw  = {30'b0, el_code};
            if (sp_eop) begin
                s_d.done = 1'b1;
                if (sp_ext) begin
                    s_d.err = 1'b1;
                end else if (el_valid) begin
                    use_loop = 1'b1;
                end
            end else if (words_nx == LAST_W) begin
                s_d.done = 1'b1;
                s_d.err  = 1'b1;
            end
            for (int k = 0; k < DEPTH; k++) begin
                if (nrec != 2'd0 && k == int'(s_q.cnt)) begin
                    s_d.recs[k] = r_a;
                end
                if (nrec == 2'd2 && k == int'(s_q.cnt) + 1) begin
                    s_d.recs[k] = r_b;
                end
                if (use_loop && k == int'(s_q.cnt) + int'(nrec)) begin
                    s_d.recs[k] = r_c;
                end
            end
            s_d.cnt = s_q.cnt + CNTW'(nrec) + CNTW'(use_loop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    rec_t rd_rec;

    always_comb begin
        rd_rec = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(rd_idx) == k) begin
                rd_rec = s_q.recs[k];
            end
        end
    end

    assign in_ready  = !s_q.done;
    assign pkt_valid = s_q.done;
    assign pkt_err   = s_q.err;
    assign pkt_count = s_q.cnt;
    assign pkt_bytes = {s_q.words, 2'b00};
    assign rd_kind   = rd_rec.kind;
    assign rd_raw    = rd_rec.raw;
    assign rd_grp    = rd_rec.grp;
    assign rd_ext    = rd_rec.ext;
    assign rd_imm    = rd_rec.imm;

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
    parameter int MAX_WORDS = 4,
    parameter int DEPTH     = 9,
    parameter int CNTW      = 4,
    parameter int BW        = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [3:0]      word_top,
    input logic [1:0]      word_parse,
    input logic            pkt_valid,
    input logic            pkt_err,
    input logic [CNTW-1:0] pkt_count,
    input logic [BW-1:0]   pkt_bytes,
    input logic            pkt_ack
);
    assert_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !in_ready);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ack) |=> (pkt_valid && $stable(pkt_count)));

    assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ack) |=> !pkt_valid);

    assert_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_bytes[1:0] == 2'b00 && pkt_bytes != '0
                       && pkt_bytes <= BW'(4 * MAX_WORDS)));

    assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> (pkt_count <= CNTW'(DEPTH)));

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> $past(in_valid && in_ready));

    assert_dangle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pkt_valid) && $past(word_top == 4'h0 && word_parse == 2'b11))
        |-> pkt_err);

    assert_overlen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pkt_valid) && $past(word_parse != 2'b11)) |-> pkt_err);
endmodule

bind pkt_framer pf_checker #(
    .MAX_WORDS (MAX_WORDS),
    .DEPTH     (DEPTH),
    .CNTW      (CNTW),
    .BW        (BW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .word_top   (in_word[31:28]),
    .word_parse (in_word[15:14]),
    .pkt_valid  (pkt_valid),
    .pkt_err    (pkt_err),
    .pkt_count  (pkt_count),
    .pkt_bytes  (pkt_bytes),
    .pkt_ack    (pkt_ack)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        pkt_valid;
    logic        pkt_err;
    logic [3:0]  pkt_count;
    logic [4:0]  pkt_bytes;
    logic        pkt_ack = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [1:0]  rd_kind;
    logic [31:0] rd_raw;
    logic [3:0]  rd_grp;
    logic        rd_ext;
    logic [31:0] rd_imm;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pkt_framer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_err(pkt_err),
        .pkt_count(pkt_count), .pkt_bytes(pkt_bytes), .pkt_ack(pkt_ack),
        .rd_idx(rd_idx), .rd_kind(rd_kind), .rd_raw(rd_raw), .rd_grp(rd_grp),
        .rd_ext(rd_ext), .rd_imm(rd_imm)
    );

    localparam int NV = 12;
    localparam logic [31:0] TW [NV][4] = '{
        '{32'h2000_C003, 32'h0, 32'h0, 32'h0},
        '{32'h3000_8007, 32'h2000_C003, 32'h0, 32'h0},
        '{32'h3000_8007, 32'h3000_8007, 32'h2000_C003, 32'h0},
        '{32'h1000_4005, 32'h3000_8007, 32'h2000_C003, 32'h0},
        '{32'h3000_8007, 32'h1000_4005, 32'h2000_C003, 32'h0},
        '{32'h1000_4005, 32'h1000_4005, 32'h3000_8007, 32'h2000_C003},
        '{32'h1000_4005, 32'h1000_4005, 32'h1000_4005, 32'h1000_4005},
        '{32'h2123_2456, 32'h2000_C003, 32'h0, 32'h0},
        '{32'hE001_2002, 32'h2000_C003, 32'h0, 32'h0},
        '{32'h0ABC_4011, 32'h2000_C003, 32'h0, 32'h0},
        '{32'h1000_4005, 32'h0ABC_C011, 32'h0, 32'h0},
        '{32'h0ABC_4011, 32'h2123_2456, 32'h2000_C003, 32'h0}
    };
    localparam int          TN [NV] = '{1, 2, 3, 3, 3, 4, 4, 2, 2, 2, 2, 3};
    localparam int          TC [NV] = '{1, 3, 4, 4, 4, 4, 4, 3, 3, 1, 1, 3};
    localparam logic        TE [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 1, 0};
    localparam logic [1:0]  TK [NV] = '{0, 3, 3, 3, 3, 0, 0, 0, 0, 0, 0, 0};
    localparam logic [31:0] TR [NV] = '{
        32'h2000_C003, 32'h1, 32'h3, 32'h2, 32'h1, 32'h2000_C003,
        32'h1000_4005, 32'h2000_C003, 32'h2000_C003, 32'h2000_C003,
        32'h1000_4005, 32'h2000_C003
    };
    localparam string TREQ [NV] = '{
        "R2", "R5", "R6", "R6", "R6", "R7", "R10", "R3", "R4", "R8", "R9", "R8"
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int v);
        for (int i = 0; i < TN[v]; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_word  = TW[v][i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic ack_pkt();
        pkt_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_ack = 1'b0;
    endtask

    task automatic read_rec(input int idx);
        rd_idx = 4'(idx);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog act=hung exp=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "in_ready", 32'(in_ready), 32'd1);
        chk("R1", "pkt_valid", 32'(pkt_valid), 32'd0);
        chk("R1", "pkt_count", 32'(pkt_count), 32'd0);

        for (int v = 0; v < NV; v++) begin
            send_pkt(v);
            chk("R2", "pkt_valid", 32'(pkt_valid), 32'd1);
            chk("R2", "pkt_bytes", 32'(pkt_bytes), 32'(4 * TN[v]));
            chk(TREQ[v], "pkt_count", 32'(pkt_count), 32'(TC[v]));
            chk(TREQ[v], "pkt_err", 32'(pkt_err), 32'(TE[v]));
            read_rec(TC[v] - 1);
            chk(TREQ[v], "last kind", 32'(rd_kind), 32'(TK[v]));
            chk(TREQ[v], "last raw", rd_raw, TR[v]);
            @(negedge clk);
            ack_pkt();
            chk("R11", "idle after ack", 32'(pkt_valid), 32'd0);
        end

        // R3: duplex order and fields
        send_pkt(7);
        read_rec(0);
        chk("R3", "rec0 kind", 32'(rd_kind), 32'd1);
        chk("R3", "rec0 raw", rd_raw, 32'h0123);
        chk("R3", "rec0 grp", 32'(rd_grp), 32'h3);
        read_rec(1);
        chk("R3", "rec1 kind", 32'(rd_kind), 32'd2);
        chk("R3", "rec1 raw", rd_raw, 32'h0456);
        chk("R3", "rec1 grp", 32'(rd_grp), 32'h3);
        @(negedge clk);
        ack_pkt();

        // R8: extender merged into the following normal word
        send_pkt(9);
        read_rec(0);
        chk("R8", "ext flag", 32'(rd_ext), 32'd1);
        chk("R8", "ext imm", rd_imm, 32'hABC0_0443);
        @(negedge clk);
        ack_pkt();

        // R8: extender applied to the upper sub-instruction only
        send_pkt(11);
        read_rec(0);
        chk("R8", "dup rec0 ext", 32'(rd_ext), 32'd1);
        chk("R8", "dup rec0 imm", rd_imm, 32'hABC0_0463);
        read_rec(1);
        chk("R8", "dup rec1 ext", 32'(rd_ext), 32'd0);
        chk("R8", "dup rec1 imm", rd_imm, 32'h16);
        @(negedge clk);
        ack_pkt();

        // R8: unextended record keeps low six bits only
        send_pkt(0);
        read_rec(0);
        chk("R8", "plain ext", 32'(rd_ext), 32'd0);
        chk("R8", "plain imm", rd_imm, 32'h3);

        // R11: stall while a packet is pending, then resume after ack
        in_valid = 1'b1;
        in_word  = 32'h1000_C00A;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R11", "stalled ready", 32'(in_ready), 32'd0);
        end
        chk("R11", "held count", 32'(pkt_count), 32'd1);
        read_rec(0);
        chk("R11", "held raw", rd_raw, 32'h2000_C003);
        pkt_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        pkt_ack = 1'b0;
        chk("R11", "ready after ack", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11", "new packet valid", 32'(pkt_valid), 32'd1);
        chk("R11", "new packet count", 32'(pkt_count), 32'd1);
        read_rec(0);
        chk("R11", "new packet raw", rd_raw, 32'h1000_C00A);
        @(negedge clk);
        ack_pkt();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule